// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of an 8-bit parallel NOR flash. It takes one program or erase request at a time on a valid/ready handshake. It generates the unlock and command write cycles on the flash bus, then reads the flash repeatedly until the status bits show that the internal operation has finished. It does not wait a fixed worst-case delay. When polling ends it raises `done` for one cycle together with a result code.

There are two ways to detect completion, and an input selects one per request. In data-polling mode, bit 7 of each status read is compared with the value the device is expected to show once the operation is finished. In toggle mode, bit 6 of two consecutive status reads is compared. While the device is still working, bit 6 changes from one read to the next. A program operation also ends with one extra read, which must return the full written byte. Polling gives up after `MAX_POLLS` status reads and then reports a timeout.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `done` is 0, `flash_dq_oe` is 0, and `flash_ce_n`, `flash_we_n` and `flash_oe_n` are all 1.
- R2: A program request (`req_op` = 0) issues exactly four write cycles, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the request address with the request data.
- R3: An erase request issues exactly six write cycles: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, and a final cycle. The final cycle depends on the operation: a 4 KB sector erase (`req_op` = 1) writes the request address with 0x30, a 64 KB block erase (`req_op` = 2) writes the request address with 0x50, and a whole-chip erase (`req_op` = 3) writes 0x555 with 0x10.
- R4: `flash_we_n` is low only while `flash_ce_n` is low and `flash_oe_n` is high. `flash_dq_oe` is never 1 while `flash_oe_n` is low.
- R5: In data-polling mode (`poll_toggle` = 0) for a program, a status read counts as completion when its bit 7 equals bit 7 of the written byte.
- R6: In data-polling mode for any erase, a status read counts as completion when its bit 7 is 1.
- R7: In toggle mode (`poll_toggle` = 1), a status read counts as completion when its bit 6 equals bit 6 of the status read just before it. The first status read after the command never counts as completion.
- R8: After completion of a program, exactly one more read is made. The result is 0 (pass) if that read equals the written byte, and 2 (verify fail) otherwise. An erase reports 0 at completion with no extra read.
- R9: If `MAX_POLLS` status reads pass without completion, the result is 1 (timeout) and no further reads are made.
- R10: `req_ready` is 0 from the cycle after a request is accepted until `done` has been high for exactly one cycle. `req_ready` returns to 1 in the cycle after `done`.
- R11: Every status read and verify read is made at the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte / sector / block address |
| req_data | input | 8 | Byte to program |
| poll_toggle | input | 1 | 0 bit-7 data polling, 1 bit-6 toggle detection |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 timeout, 2 verify fail; valid with done |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 8 | Data driven onto the flash data bus |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | 8 | Data read from the flash data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach is in toggle mode: whether completion is seen on the first valid read or one read later depends on the phase of bit 6 during the busy reads compared with bit 6 of the final data. A timeout that lands exactly on the last allowed read is also hard to reach. The bench contains a flash model whose busy period lasts a chosen number of reads. It sweeps that length from zero past `MAX_POLLS` for every operation, both modes, several data bytes, and with the final data either correct or corrupted in bit 0. For each combination it works out arithmetically which read must complete, and checks the result code, the total number of reads and the write sequence.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_PASS    = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_VFAIL   = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_GO,
    S_WR_WAIT,
    S_RD_GO,
    S_RD_WAIT,
    S_VF_GO,
    S_VF_WAIT,
    S_FIN
  } ctl_st_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_SETUP,
    P_ACTIVE,
    P_RECOV
  } phy_st_e;

  localparam logic [11:0] UNLOCK_A1 = 12'h555;
  localparam logic [11:0] UNLOCK_A2 = 12'h2AA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_BLOCK = 8'h50;

endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
  import fpc_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic [1:0]    op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          last
);

  localparam logic [AW-1:0] A1 = AW'(UNLOCK_A1);
  localparam logic [AW-1:0] A2 = AW'(UNLOCK_A2);

  logic is_prog;
  assign is_prog = (op == OP_PROG);

  always_comb begin
    wr_addr = A1;
    wr_data = KEY_1;
    last    = 1'b0;
    case (step)
      3'd0: begin
        wr_addr = A1;
        wr_data = KEY_1;
      end
      3'd1: begin
        wr_addr = A2;
        wr_data = KEY_2;
      end
      3'd2: begin
        wr_addr = A1;
        wr_data = is_prog ? CMD_PROG : CMD_ERASE;
      end
      3'd3: begin
        if (is_prog) begin
          wr_addr = tgt_addr;
          wr_data = tgt_data;
          last    = 1'b1;
        end else begin
          wr_addr = A1;
          wr_data = KEY_1;
        end
      end
      3'd4: begin
        wr_addr = A2;
        wr_data = KEY_2;
      end
      default: begin
        last = 1'b1;
        if (op == OP_CHIP) begin
          wr_addr = A1;
          wr_data = CMD_CHIP;
        end else begin
          wr_addr = tgt_addr;
          wr_data = (op == OP_BLOCK) ? CMD_BLOCK : CMD_SECT;
        end
      end
    endcase
  end

endmodule

// File: rtl/fpc_bus_phy.sv
module fpc_bus_phy
  import fpc_pkg::*;
#(
  parameter int AW         = 18,
  parameter int PULSE_CYC  = 2,
  parameter int STROBE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    wdata_in,
  input  logic [7:0]    dq_in,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          cyc_done,
  output logic [7:0]    rdata
);

  localparam int MAXC = (PULSE_CYC > STROBE_CYC) ? PULSE_CYC : STROBE_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] WR_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(STROBE_CYC - 1);

  phy_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wd_q;
  logic [7:0]    rdata_q;
  logic          load, cap;
  logic [CW-1:0] last_cnt;

  assign last_cnt = rd_q ? RD_LAST : WR_LAST;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    cap   = 1'b0;
    case (st_q)
      P_IDLE: begin
        if (start) begin
          load  = 1'b1;
          cnt_d = '0;
          st_d  = P_SETUP;
        end
      end
      P_SETUP: begin
        cnt_d = '0;
        st_d  = P_ACTIVE;
      end
      P_ACTIVE: begin
        if (cnt_q == last_cnt) begin
          cap  = rd_q;
          st_d = P_RECOV;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= P_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (load) begin
      rd_q   <= is_rd;
      addr_q <= addr_in;
      wd_q   <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap) begin
      rdata_q <= dq_in;
    end
  end

  assign ce_n     = !((st_q == P_SETUP) || (st_q == P_ACTIVE));
  assign we_n     = !((st_q == P_ACTIVE) && !rd_q);
  assign oe_n     = !((st_q == P_ACTIVE) && rd_q);
  assign dq_oe    = !rd_q && (st_q != P_IDLE);
  assign bus_addr = addr_q;
  assign dq_out   = wd_q;
  assign cyc_done = (st_q == P_RECOV);
  assign rdata    = rdata_q;

endmodule

// File: rtl/fpc_judge.sv
module fpc_judge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic [7:0] rd_val,
  input  logic       toggle_mode,
  input  logic       erase_op,
  input  logic       exp_b7,
  output logic       complete
);

  logic have_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (clear) begin
      have_q <= 1'b0;
    end else if (sample) begin
      have_q <= 1'b1;
      prev_q <= rd_val[6];
    end
  end

  always_comb begin
    if (toggle_mode) begin
      complete = have_q && (rd_val[6] == prev_q);
    end else if (erase_op) begin
      complete = rd_val[7];
    end else begin
      complete = (rd_val[7] == exp_b7);
    end
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int AW         = 18,
  parameter int PULSE_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int MAX_POLLS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_toggle,
  output logic          done,
  output logic [1:0]    result,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_dq_in,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n
);

  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  ctl_st_e       st_q, st_d;
  logic [2:0]    step_q, step_d;
  logic [PW-1:0] poll_q, poll_d;
  res_e          res_q, res_d;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          mode_q;
  logic          take, j_clr, j_smp, j_complete;

  logic          phy_start, phy_is_rd, phy_done;
  logic [AW-1:0] phy_addr;
  logic [7:0]    phy_rdata;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          cmd_last;

  fpc_cmd_table #(.AW(AW)) u_cmd (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .wr_addr  (cmd_addr),
    .wr_data  (cmd_data),
    .last     (cmd_last)
  );

  assign phy_start = (st_q == S_WR_GO) || (st_q == S_RD_GO) || (st_q == S_VF_GO);
  assign phy_is_rd = (st_q != S_WR_GO);
  assign phy_addr  = (st_q == S_WR_GO) ? cmd_addr : addr_q;

  fpc_bus_phy #(
    .AW         (AW),
    .PULSE_CYC  (PULSE_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (phy_start),
    .is_rd    (phy_is_rd),
    .addr_in  (phy_addr),
    .wdata_in (cmd_data),
    .dq_in    (flash_dq_in),
    .bus_addr (flash_addr),
    .dq_out   (flash_dq_out),
    .dq_oe    (flash_dq_oe),
    .ce_n     (flash_ce_n),
    .we_n     (flash_we_n),
    .oe_n     (flash_oe_n),
    .cyc_done (phy_done),
    .rdata    (phy_rdata)
  );

  fpc_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (j_clr),
    .sample      (j_smp),
    .rd_val      (phy_rdata),
    .toggle_mode (mode_q),
    .erase_op    (op_q != OP_PROG),
    .exp_b7      (data_q[7]),
    .complete    (j_complete)
  );

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    poll_d = poll_q;
    res_d  = res_q;
    take   = 1'b0;
    j_clr  = 1'b0;
    j_smp  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          take   = 1'b1;
          step_d = '0;
          st_d   = S_WR_GO;
        end
      end
      S_WR_GO: st_d = S_WR_WAIT;
      S_WR_WAIT: begin
        if (phy_done) begin
          if (cmd_last) begin
            poll_d = '0;
            j_clr  = 1'b1;
            st_d   = S_RD_GO;
          end else begin
            step_d = step_q + 3'd1;
            st_d   = S_WR_GO;
          end
        end
      end
      S_RD_GO: st_d = S_RD_WAIT;
      S_RD_WAIT: begin
        if (phy_done) begin
          j_smp  = 1'b1;
          poll_d = poll_q + 1'b1;
          if (j_complete) begin
            if (op_q == OP_PROG) begin
              st_d = S_VF_GO;
            end else begin
              res_d = RES_PASS;
              st_d  = S_FIN;
            end
          end else if (poll_q == POLL_LAST) begin
            res_d = RES_TIMEOUT;
            st_d  = S_FIN;
          end else begin
            st_d = S_RD_GO;
          end
        end
      end
      S_VF_GO: st_d = S_VF_WAIT;
      S_VF_WAIT: begin
        if (phy_done) begin
          res_d = (phy_rdata == data_q) ? RES_PASS : RES_VFAIL;
          st_d  = S_FIN;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      poll_q <= '0;
      res_q  <= RES_PASS;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      poll_q <= poll_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (take) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
      mode_q <= poll_toggle;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign done      = (st_q == S_FIN);
  assign result    = res_q;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int MAX_POLLS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] result,
  input logic       flash_ce_n,
  input logic       flash_we_n,
  input logic       flash_oe_n,
  input logic       flash_dq_oe
);

  logic        oe_q;
  logic [15:0] rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= 1'b1;
      rd_cnt_q <= '0;
    end else begin
      oe_q <= flash_oe_n;
      if (req_valid && req_ready) begin
        rd_cnt_q <= '0;
      end else if (oe_q && !flash_oe_n) begin
        rd_cnt_q <= rd_cnt_q + 16'd1;
      end
    end
  end

  assert_wr_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_dq_oe |-> flash_oe_n);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_done_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  assert_result_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));

  assert_timeout_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd1) |-> (rd_cnt_q == 16'(MAX_POLLS)));

  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_cnt_q <= 16'(MAX_POLLS + 1)));

endmodule

bind flash_poll_ctrl fpc_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .result      (result),
  .flash_ce_n  (flash_ce_n),
  .flash_we_n  (flash_we_n),
  .flash_oe_n  (flash_oe_n),
  .flash_dq_oe (flash_dq_oe)
);

// File: tb/sim_flash_poll_ctrl.sv
`timescale 1ns/1ps
module sim_flash_poll_ctrl;

  localparam int AW   = 18;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          poll_toggle = 1'b0;
  logic          done;
  logic [1:0]    result;
  logic [AW-1:0] flash_addr;
  logic [7:0]    flash_dq_out;
  logic          flash_dq_oe;
  logic [7:0]    flash_dq_in;
  logic          flash_ce_n, flash_we_n, flash_oe_n;

  always #5 clk = ~clk;

  flash_poll_ctrl #(
    .AW(AW), .PULSE_CYC(2), .STROBE_CYC(2), .MAX_POLLS(MAXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .poll_toggle(poll_toggle), .done(done), .result(result),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
    .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
    .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
  );

  int checks = 0;
  int fails  = 0;

  // flash model state
  int cur_op = 0, cur_data = 0, cur_busy = 0, cur_addr = 0;
  bit cur_cor = 1'b0;
  int rd_idx = 0, rcount = 0, wcount = 0, viol = 0, addr_bad = 0;
  int wlog [8];
  bit in_wr = 1'b0, in_rd = 1'b0;

  function automatic logic [7:0] mval(int j, int op, int d, int b, bit cor);
    logic [7:0] v;
    if (j <= b) begin
      if (op == 0) v = {~d[7], j[0], 6'b0};
      else         v = {1'b0,  j[0], 6'b0};
    end else begin
      if (op == 0) v = cor ? (d[7:0] ^ 8'h01) : d[7:0];
      else         v = 8'hFF;
    end
    return v;
  endfunction

  assign flash_dq_in = mval(rd_idx, cur_op, cur_data, cur_busy, cur_cor);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!flash_ce_n && !flash_we_n && !in_wr) begin
        in_wr = 1'b1;
        if (wcount < 8) wlog[wcount] = (int'(flash_addr) << 8) | int'(flash_dq_out);
        wcount++;
        rd_idx = 0;
      end
      if (flash_we_n) in_wr = 1'b0;
      if (!flash_oe_n && !in_rd) begin
        in_rd = 1'b1;
        rd_idx++;
        rcount++;
        if (int'(flash_addr) != cur_addr) addr_bad++;
      end
      if (flash_oe_n) in_rd = 1'b0;
      if (!flash_we_n && (flash_ce_n || !flash_oe_n)) viol++;
      if (flash_dq_oe && !flash_oe_n) viol++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_w(int op, int i, int a, int d);
    case (i)
      0: return (12'h555 << 8) | 8'hAA;
      1: return (12'h2AA << 8) | 8'h55;
      2: return (12'h555 << 8) | ((op == 0) ? 8'hA0 : 8'h80);
      3: return (op == 0) ? ((a << 8) | d) : ((12'h555 << 8) | 8'hAA);
      4: return (12'h2AA << 8) | 8'h55;
      default: begin
        if (op == 3) return (12'h555 << 8) | 8'h10;
        return (a << 8) | ((op == 1) ? 8'h30 : 8'h50);
      end
    endcase
  endfunction

  bit aborted = 1'b0;

  task automatic run_one(int op, bit tog, int b, int d, bit cor);
    int k, exp_res, exp_reads, nw, wait_cyc;
    bit found;
    string tag;
    logic [7:0] v, vp;
    // expected outcome from the requirements
    found = 1'b0;
    k = 0;
    for (int j = 1; j <= MAXP; j++) begin
      if (!found) begin
        v  = mval(j, op, d, b, cor);
        vp = mval(j - 1, op, d, b, cor);
        if (tog) begin
          if (j >= 2 && v[6] == vp[6]) found = 1'b1;
        end else if (op == 0) begin
          if (v[7] == d[7]) found = 1'b1;
        end else begin
          if (v[7]) found = 1'b1;
        end
        if (found) k = j;
      end
    end
    if (!found) begin
      exp_res = 1; exp_reads = MAXP; tag = "R9";
    end else if (op == 0) begin
      exp_reads = k + 1;
      exp_res   = cor ? 2 : 0;
      tag       = cor ? "R8" : (tog ? "R7" : "R5");
    end else begin
      exp_reads = k; exp_res = 0; tag = tog ? "R7" : "R6";
    end
    nw = (op == 0) ? 4 : 6;

    @(negedge clk);
    cur_op = op; cur_data = d; cur_busy = b; cur_cor = cor;
    cur_addr = 18'h01000 * (b + 1) + d + op * 18'h10000;
    rcount = 0; wcount = 0; viol = 0; addr_bad = 0; rd_idx = 0;
    req_op = 2'(op); req_addr = AW'(cur_addr); req_data = 8'(d);
    poll_toggle = tog; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc = 0;
    while (!done && wait_cyc < 2000) begin
      if (req_ready) begin
        chk(1'b0, "R10 ready while busy", 1, 0);
      end
      @(negedge clk);
      wait_cyc++;
    end
    if (!done) begin
      chk(1'b0, "R10 watchdog", 0, 1);
      aborted = 1'b1;
      return;
    end
    chk(int'(result) == exp_res, tag, int'(result), exp_res);
    chk(rcount == exp_reads, {tag, " read count"}, rcount, exp_reads);
    chk(wcount == nw, (op == 0) ? "R2 write count" : "R3 write count", wcount, nw);
    for (int i = 0; i < nw && i < 8 && i < wcount; i++) begin
      chk(wlog[i] == exp_w(op, i, cur_addr, d),
          (op == 0) ? "R2 write cycle" : "R3 write cycle", wlog[i], exp_w(op, i, cur_addr, d));
    end
    chk(viol == 0, "R4 bus strobe rule", viol, 0);
    chk(addr_bad == 0, "R11 read address", addr_bad, 0);
    chk(!req_ready, "R10 ready during done", int'(req_ready), 0);
    @(negedge clk);
    chk(!done && req_ready, "R10 done pulse then ready", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R10 global watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int dv [4];
    dv[0] = 8'h00; dv[1] = 8'hFF; dv[2] = 8'h5A; dv[3] = 8'hA5;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !flash_dq_oe && flash_ce_n && flash_we_n && flash_oe_n,
        "R1 in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !flash_dq_oe && flash_ce_n && flash_we_n && flash_oe_n,
        "R1 after reset", int'(req_ready), 1);
    for (int op = 0; op < 4; op++) begin
      for (int tg = 0; tg < 2; tg++) begin
        for (int b = 0; b <= MAXP + 1; b++) begin
          for (int di = 0; di < ((op == 0) ? 4 : 1); di++) begin
            for (int c = 0; c < ((op == 0) ? 2 : 1); c++) begin
              if (!aborted) run_one(op, tg[0], b, dv[di], c[0]);
            end
          end
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule